// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is the device-side control of a small synchronous burst static RAM. At every rising clock edge it samples three chip enables, a processor address strobe, a controller address strobe, a burst-advance input, a sleep input and the write-enable group. The write-enable group is a global write, a byte-write enable and one enable per byte lane. From these inputs it classifies the cycle as one of the following:

- a deselect;
- a new access at the external address;
- a burst continuation at the next address;
- a suspension at the current address;
- an idle cycle.

It then performs the read or write on an internal array of 64 words of 18 bits. Each word holds two lanes, and each lane is an 8-bit byte plus one parity bit.

The data bus is modelled as three signals: a read-data output, a drive-enable output that stands for the tri-state control, and a write-data input. The drive enable depends combinationally on an asynchronous output-enable pin. Write cycles mask that pin. All pins are plain control and data pins. The memory-side protocol has no back-pressure, so there is no valid/ready interface. Every sampled cycle is accepted at the clock edge.

Top module: `sram_burst_ctl`

## Requirements
- R1: While `sleep` is high at a clock edge, that edge writes nothing and changes no address, and `dq_drive` is low after it.
- R2: A cycle deselects the device when `ce1_n` is high with `adsc_n` low, or when (`adsc_n` is low, or `adsp_n` is low with `ce1_n` low) while `ce2` is low or `ce3_n` is high. `dq_drive` is then low after the edge. Later continue or suspend cycles do nothing until a new access starts.
- R3: With `ce1_n`=0, `ce2`=1, `ce3_n`=0 and `adsp_n`=0, a read starts at `addr`, whatever `gw_n`, `bwe_n` and `bw_n` are.
- R4: With `adsp_n`=1, `adsc_n`=0 and all chip enables active, an access starts at `addr`. It is a write when the internal write term is active and a read otherwise.
- R5: While `ce1_n` is high, `adsp_n` is ignored. With `adsc_n` high the cycle is a continue or suspend cycle, even if `ce2` is low.
- R6: A cycle with both strobes inactive and `adv_n`=0 uses the next address. Address bits [1:0] count up in linear order and wrap from 3 to 0, and bits [5:2] are held.
- R7: A cycle with both strobes inactive and `adv_n`=1 reuses the current address, so the read data stays the same.
- R8: The write term is active when `gw_n`=0, or when `bwe_n`=0 with at least one `bw_n` bit low. `gw_n`=0 writes both lanes. Otherwise exactly the lanes with a low `bw_n` bit are written. Lane A is `dq_in[8:0]` (byte in [7:0], parity in bit 8) and is enabled by `bw_n[0]`. Lane B is `dq_in[17:9]` and is enabled by `bw_n[1]`.
- R9: `dq_drive` is high only when the last clocked cycle was a read of a selected device and `oe_n` is low. It follows `oe_n` without a clock, and it is low after any write cycle even with `oe_n` low.
- R10: The word at a read cycle's address appears on `dq_out` immediately after the edge that registers that address.
- R11: After reset the device is deselected and `dq_drive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep | input | 1 | Sleep: when high, the edge does nothing |
| ce1_n | input | 1 | Chip enable 1, active low; gates the processor strobe |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| adsp_n | input | 1 | Processor address strobe, active low; always starts a read |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 2 | Per-lane write enables, active low; bit 0 is lane A |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | 6 | External word address |
| dq_in | input | 18 | Write data from the bus |
| dq_out | output | 18 | Read data toward the bus |
| dq_drive | output | 1 | Bus drive enable; low means the bus is tri-stated |

## Verification
A wrong burst-address register shows on `dq_out` at the first read after the fault. A continue or suspend cycle then returns the word from a neighbouring location, or from the wrong group of four. A wrong selection or read-activity flag shows at once on `dq_drive` after the edge: the bus is either driven during a write, sleep or deselect, or stays undriven during a read. A wrong lane decode only shows later, when the word is read back with one lane or its parity bit wrong. For that reason every write scenario ends with a read at the affected address.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  // Classification of one sampled clock cycle.
  typedef enum logic [2:0] {
    CYC_IDLE  = 3'd0,  // sleep, or continue/suspend while deselected
    CYC_DESEL = 3'd1,  // device deselected
    CYC_EXT   = 3'd2,  // new access at external address
    CYC_NEXT  = 3'd3,  // burst continue, next address
    CYC_HOLD  = 3'd4   // burst suspend, current address
  } cyc_e;

endpackage

// File: rtl/sram_cycle_decode.sv
module sram_cycle_decode
  import sram_ctl_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             sleep,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             adsp_n,
  input  logic             adsc_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  input  logic             sel_q,
  output cyc_e             cyc,
  output logic             is_write,
  output logic [LANES-1:0] lane_we,
  output logic             sel_d
);

  logic write_n;
  logic far_off;    // ce2 or ce3 inactive
  logic strobe_p;   // processor strobe, qualified by ce1
  logic desel;

  // Combined write term: active low.
  assign write_n  = gw_n & (bwe_n | (&bw_n));
  assign far_off  = ~ce2 | ce3_n;
  assign strobe_p = ~adsp_n & ~ce1_n;
  assign desel    = (~adsc_n & ce1_n) | ((strobe_p | ~adsc_n) & far_off);

  always_comb begin
    cyc      = CYC_IDLE;
    is_write = 1'b0;
    sel_d    = sel_q;
    if (sleep) begin
      cyc = CYC_IDLE;
    end else if (desel) begin
      cyc   = CYC_DESEL;
      sel_d = 1'b0;
    end else if (strobe_p) begin
      // processor strobe always reads
      cyc   = CYC_EXT;
      sel_d = 1'b1;
    end else if (~adsc_n) begin
      cyc      = CYC_EXT;
      is_write = ~write_n;
      sel_d    = 1'b1;
    end else if (sel_q) begin
      cyc      = adv_n ? CYC_HOLD : CYC_NEXT;
      is_write = ~write_n;
    end
  end

  // Lane enables: global write covers every lane.
  always_comb begin
    if (!is_write)  lane_we = '0;
    else if (!gw_n) lane_we = '1;
    else            lane_we = ~bw_n;
  end

endmodule

// File: rtl/sram_burst_addr.sv
module sram_burst_addr
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cyc_e              cyc,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] addr_cur
);

  localparam int UP_W = ADDR_W - BURST_W;

  logic [ADDR_W-1:0]  addr_q;
  logic [BURST_W-1:0] low_inc;

  assign low_inc = addr_q[BURST_W-1:0] + BURST_W'(1);

  always_comb begin
    unique case (cyc)
      CYC_EXT:  addr_cur = ext_addr;
      CYC_NEXT: addr_cur = {addr_q[ADDR_W-1:BURST_W], low_inc};
      default:  addr_cur = addr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (cyc == CYC_EXT || cyc == CYC_NEXT) addr_q <= addr_cur;
  end

  // R6: continue steps the low bits by one with wrap; upper bits held
  a_r6_linear_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_NEXT) |=>
      (addr_q[BURST_W-1:0] == BURST_W'($past(addr_q[BURST_W-1:0]) + BURST_W'(1))) &&
      (addr_q[ADDR_W-1:BURST_W] == UP_W'($past(addr_q[ADDR_W-1:BURST_W]))));

  // R7: suspend keeps the registered address
  a_r7_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_HOLD) |=> $stable(addr_q));

endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES-1:0]          lane_we,
  input  logic                      rd_en,
  input  logic [LANES*LANE_W-1:0]   wdata,
  output logic [LANES*LANE_W-1:0]   rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
      if (rd_en)      rd_q      <= mem[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/sram_burst_ctl.sv
module sram_burst_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 2,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sleep,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    adsp_n,
  input  logic                    adsc_n,
  input  logic                    adv_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    oe_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_drive
);

  cyc_e              cyc;
  logic              is_write;
  logic [LANES-1:0]  lane_we;
  logic              sel_d, sel_q;
  logic              rd_q;
  logic              rd_en;
  logic [ADDR_W-1:0] addr_cur;

  sram_cycle_decode #(.LANES(LANES)) u_decode (
    .sleep   (sleep),
    .ce1_n   (ce1_n),
    .ce2     (ce2),
    .ce3_n   (ce3_n),
    .adsp_n  (adsp_n),
    .adsc_n  (adsc_n),
    .adv_n   (adv_n),
    .gw_n    (gw_n),
    .bwe_n   (bwe_n),
    .bw_n    (bw_n),
    .sel_q   (sel_q),
    .cyc     (cyc),
    .is_write(is_write),
    .lane_we (lane_we),
    .sel_d   (sel_d)
  );

  sram_burst_addr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .cyc     (cyc),
    .ext_addr(addr),
    .addr_cur(addr_cur)
  );

  assign rd_en = ((cyc == CYC_EXT) || (cyc == CYC_NEXT) || (cyc == CYC_HOLD)) && !is_write;

  sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk    (clk),
    .addr   (addr_cur),
    .lane_we(lane_we),
    .rd_en  (rd_en),
    .wdata  (dq_in),
    .rdata  (dq_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      sel_q <= sel_d;
      rd_q  <= rd_en;
    end
  end

  // Output enable is asynchronous; write and idle cycles clear rd_q.
  assign dq_drive = rd_q & ~oe_n;

  // R1: sleep writes nothing and leaves the bus undriven
  a_r1_sleep_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (lane_we == '0));
  a_r1_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !dq_drive);

  // R2: controller strobe with ce1 inactive deselects
  a_r2_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && ce1_n && !adsc_n) |=> !dq_drive);

  // R3: processor strobe with all enables active never writes
  a_r3_adsp_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !ce1_n && ce2 && !ce3_n && !adsp_n) |-> (lane_we == '0));

  // R9: output enable is masked after a write
  a_r9_write_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_we) |=> !dq_drive);

endmodule

// File: tb/sram_burst_ctl_bench.sv
module sram_burst_ctl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep = 1'b0;
  logic        ce1_n = 1'b1, ce2 = 1'b1, ce3_n = 1'b0;
  logic        adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
  logic        gw_n = 1'b1, bwe_n = 1'b1;
  logic [1:0]  bw_n = 2'b11;
  logic        oe_n = 1'b0;
  logic [5:0]  addr = '0;
  logic [17:0] dq_in = '0;
  logic [17:0] dq_out;
  logic        dq_drive;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sram_burst_ctl u_sram_burst_ctl (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .addr(addr),
    .dq_in(dq_in), .dq_out(dq_out), .dq_drive(dq_drive)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_in(input logic c1n, input logic c2, input logic c3n,
                        input logic pn, input logic cn, input logic vn,
                        input logic gwn, input logic bwen, input logic [1:0] bwn,
                        input logic [5:0] a, input logic [17:0] d);
    ce1_n = c1n; ce2 = c2; ce3_n = c3n; adsp_n = pn; adsc_n = cn; adv_n = vn;
    gw_n = gwn; bwe_n = bwen; bw_n = bwn; addr = a; dq_in = d;
  endtask

  task automatic do_adsp(input logic [5:0] a);
    set_in(0, 1, 0, 0, 1, 1, 1, 1, 2'b11, a, '0); tick();
  endtask

  task automatic do_adsc(input logic [5:0] a, input logic gwn, input logic bwen,
                         input logic [1:0] bwn, input logic [17:0] d);
    set_in(0, 1, 0, 1, 0, 1, gwn, bwen, bwn, a, d); tick();
  endtask

  task automatic do_burst(input logic vn, input logic gwn, input logic [17:0] d);
    set_in(0, 1, 0, 1, 1, vn, gwn, 1, 2'b11, 6'h3f, d); tick();
  endtask

  task automatic t_reset();
    check("R11 drive after reset", dq_drive, 0);
  endtask

  task automatic t_ext_write_read();
    do_adsc(6'd8, 0, 1, 2'b11, 18'h12345);
    check("R9 write masks oe", dq_drive, 0);
    do_adsp(6'd8);
    check("R4/R10 read back", dq_out, 18'h12345);
    check("R9 drive on read", dq_drive, 1);
  endtask

  task automatic t_burst_wrap();
    do_adsc(6'd12, 0, 1, 2'b11, 18'h10001);
    do_burst(0, 0, 18'h10002);
    do_burst(0, 0, 18'h10003);
    do_burst(0, 0, 18'h10004);
    check("R9 burst write drive", dq_drive, 0);
    do_burst(0, 0, 18'h10005);  // wraps to 12
    do_adsp(6'd14);
    check("R3 read at 14", dq_out, 18'h10003);
    do_burst(0, 1, '0);
    check("R6 next is 15", dq_out, 18'h10004);
    do_burst(0, 1, '0);
    check("R6 wrap to 12", dq_out, 18'h10005);
    do_burst(1, 1, '0);
    check("R7 suspend holds", dq_out, 18'h10005);
    check("R7 drive in suspend", dq_drive, 1);
    do_burst(0, 1, '0);
    check("R6 then 13", dq_out, 18'h10002);
  endtask

  task automatic t_ce1_ignore();
    // ce1 high, adsp low, ce2 low: still a continue
    set_in(1, 0, 0, 0, 1, 0, 1, 1, 2'b11, 6'h00, '0); tick();
    check("R5 adsp ignored, continue to 14", dq_out, 18'h10003);
    check("R5 still driving", dq_drive, 1);
    set_in(1, 1, 0, 1, 0, 1, 1, 1, 2'b11, 6'h00, '0); tick();
    check("R2 ce1 high with adsc deselects", dq_drive, 0);
  endtask

  task automatic t_adsp_forces_read();
    set_in(0, 1, 0, 0, 1, 1, 0, 0, 2'b00, 6'd8, 18'h3ffff); tick();
    check("R3 adsp ignores write inputs", dq_out, 18'h12345);
    check("R3 adsp drives", dq_drive, 1);
    do_adsp(6'd8);
    check("R3 memory untouched", dq_out, 18'h12345);
  endtask

  task automatic t_byte_lanes();
    logic [17:0] d;
    d = 18'h2aaaa;
    do_adsc(6'd20, 0, 1, 2'b11, 18'h3ffff);
    do_adsc(6'd20, 1, 0, 2'b10, 18'h00000);  // lane A only
    do_adsc(6'd20, 1, 0, 2'b01, d);          // lane B only
    do_adsc(6'd20, 1, 0, 2'b11, 18'h3ffff);  // no lane: a read
    check("R8 lanes merged", dq_out, {14'h0, d[17:9], 9'h000});
    check("R4 adsc read drives", dq_drive, 1);
    do_adsc(6'd20, 1, 1, 2'b00, 18'h3ffff);  // bwe high: read
    check("R8 bwe high is read", dq_out, {14'h0, d[17:9], 9'h000});
  endtask

  task automatic t_oe_async();
    do_adsp(6'd8);
    oe_n = 1'b1; #2;
    check("R9 oe high no drive", dq_drive, 0);
    oe_n = 1'b0; #2;
    check("R9 oe low drives", dq_drive, 1);
  endtask

  task automatic t_sleep();
    sleep = 1'b1;
    do_adsc(6'd8, 0, 1, 2'b11, 18'h00bad);
    check("R1 sleep no drive", dq_drive, 0);
    sleep = 1'b0;
    do_adsp(6'd8);
    check("R1 sleep wrote nothing", dq_out, 18'h12345);
  endtask

  task automatic t_deselect();
    set_in(0, 0, 0, 0, 1, 1, 1, 1, 2'b11, 6'd8, '0); tick();
    check("R2 ce2 low deselects", dq_drive, 0);
    do_burst(0, 0, 18'h0f0f0);
    check("R2 continue while deselected", dq_drive, 0);
    set_in(0, 1, 1, 1, 0, 1, 0, 1, 2'b11, 6'd8, 18'h0f0f0); tick();
    check("R2 ce3 high deselects", dq_drive, 0);
    do_adsp(6'd8);
    check("R2 no write while deselected", dq_out, 18'h12345);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #23;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_ext_write_read();
    t_burst_wrap();
    t_ce1_ignore();
    t_adsp_forces_read();
    t_byte_lanes();
    t_oe_async();
    t_sleep();
    t_deselect();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule